// File: doc/BRIEF.md
# Serial Multiply-Accumulate Neuron with Sigmoid Output

This block is one artificial neuron that takes its weighted inputs one per clock. A load pulse writes a signed bias into the accumulator and opens a pass. Each accepted input sample is multiplied by its weight on a single shared multiplier, and the product is added to the running sum. When the fan-in count of products has been added, the signed sum is shifted into a 9-bit unsigned activation argument. That argument is saturated at both ends and then fed to a built-in piecewise second-order sigmoid approximation. The result is an 8-bit unsigned output marked by a one-cycle valid strobe. Layer sequencing and weight storage sit outside the block, which only sees the serial stream.

Control is a four-state machine. `PH_IDLE` is the state after reset and after each result. In it, input samples are ignored and only a load leaves it (transition *arm*, to `PH_ACCUM`). `PH_ACCUM` counts accepted samples. The FAN_IN-th accepted sample takes it to `PH_CLAMP` (transition *sum done*). `PH_CLAMP` registers the saturated argument and always moves to `PH_ACTIVATE` (transition *argument ready*). `PH_ACTIVATE` registers the sigmoid result, raises the valid strobe and returns to `PH_IDLE` (transition *result issued*). A load in any state overrides all of these and goes to `PH_ACCUM` (transition *restart*). A pass that is in flight when a load arrives is abandoned.

Top module: `serial_neuron`

## Requirements
- R1: While reset is asserted and after it is released, `out_valid` is 0 and `out_y` is 0 until the first result.
- R2: Samples presented with `in_valid` before the first `load` after reset are ignored: no `out_valid` appears, and the next pass gives the result computed without them.
- R3: A `load` cycle writes the two's-complement `bias` (sign-extended) into the accumulator, discards any partial sum and restarts the input count. A sample presented in the same cycle as `load` is not accumulated.
- R4: In `PH_ACCUM`, every cycle with `in_valid` high adds the signed product `in_x * in_w` (both 8-bit two's complement) to the sum. Cycles with `in_valid` low add nothing, so gaps between samples are allowed.
- R5: After the FAN_IN-th accepted sample (default 8), `out_valid` is high for exactly one cycle, in the cycle after the third rising edge counted from the edge that takes that sample. `out_y` keeps its value until the next result.
- R6: The activation argument is the sum plus 256, saturated to 0..511. A sum of -256 or below gives 0; a sum of 255 or above gives 511.
- R7: For argument a, `out_y` is within 4 LSB of 255/(1+exp(-(a-256)/32)). Argument 0 gives exactly 0, argument 511 gives exactly 255 and argument 256 gives exactly 128.
- R8: `out_y` is monotonic non-decreasing in the activation argument over 0..511.
- R9: A `load` during a pass, including during the two stages after the last sample, abandons that pass. No `out_valid` is produced for it, and the load opens a new pass seeded with the new bias.
- R10: After a result, samples with `in_valid` are ignored until the next `load`: no `out_valid`, and `out_y` is unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| load | input | 1 | Seeds the accumulator with `bias` and starts a pass |
| bias | input | BIAS_W (16) | Signed bias value, two's complement |
| in_valid | input | 1 | Marks a valid input sample and weight |
| in_x | input | DATA_W (8) | Signed input sample |
| in_w | input | DATA_W (8) | Signed weight for the sample |
| out_y | output | 8 | Unsigned activation result |
| out_valid | output | 1 | One-cycle strobe marking a new `out_y` |

## Verification
All inputs are driven and all outputs sampled on the falling edge. The rising edge that takes the last sample is counted as edge one. The bench then expects `out_valid` low after edges one and two, high after edge three with the result, and low again after edge four with `out_y` held. This window is checked on every pass. Abandon and ignore cases are observed at each falling edge across the whole window in which a strobe could otherwise appear. A full sweep of all 512 arguments, reached through the bias with zero inputs, checks the result against the ideal curve, monotonicity and the exact end points. The measured sweep table is then the exact reference for mixed-sign input passes, whose argument the bench computes itself.

// File: rtl/neuron_pkg.sv
package neuron_pkg;

    localparam int ARG_W   = 9;
    localparam int Y_W     = 8;
    localparam int ARG_MID = 256;
    localparam int ARG_MAX = 511;
    localparam int Y_MID   = 128;
    localparam int Y_MAX   = 255;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_ACCUM,
        PH_CLAMP,
        PH_ACTIVATE
    } phase_t;

    // Quadratic segment coefficients, scaled by 16, for the upper half of
    // the curve. Each segment spans 64 argument steps (two units of x).
    function automatic int coef_base(input logic [1:0] seg);
        int r;
        unique case (seg)
            2'd0: r = 0;
            2'd1: r = 1554;
            2'd2: r = 1967;
            2'd3: r = 2030;
        endcase
        return r;
    endfunction

    function automatic int coef_lin(input logic [1:0] seg);
        int r;
        unique case (seg)
            2'd0: r = 2217;
            2'd1: r = 759;
            2'd2: r = 121;
            2'd3: r = 17;
        endcase
        return r;
    endfunction

    function automatic int coef_quad(input logic [1:0] seg);
        int r;
        unique case (seg)
            2'd0: r = -664;
            2'd1: r = -346;
            2'd2: r = -58;
            2'd3: r = -8;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/neuron_ctrl.sv
module neuron_ctrl
    import neuron_pkg::*;
#(
    parameter int FAN_IN = 8
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   load,
    input  logic   in_valid,
    output phase_t phase,
    output logic   seed,
    output logic   take,
    output logic   arg_en,
    output logic   res_en
);

    localparam int CNT_W = (FAN_IN > 1) ? $clog2(FAN_IN) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(FAN_IN - 1);

    phase_t           phase_q;
    phase_t           phase_d;
    logic [CNT_W-1:0] cnt_q;
    logic             at_last;

    assign at_last = (cnt_q == LAST);
    assign phase   = phase_q;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
        end else begin
            phase_q <= phase_d;
        end
    end

    // Transitions: restart has priority over every other move
    always_comb begin
        phase_d = phase_q;
        if (load) begin
            phase_d = PH_ACCUM;
        end else begin
            unique case (phase_q)
                PH_IDLE:     phase_d = PH_IDLE;
                PH_ACCUM:    if (in_valid && at_last) phase_d = PH_CLAMP;
                PH_CLAMP:    phase_d = PH_ACTIVATE;
                PH_ACTIVATE: phase_d = PH_IDLE;
            endcase
        end
    end

    // Per-state datapath enables
    always_comb begin
        seed   = load;
        take   = 1'b0;
        arg_en = 1'b0;
        res_en = 1'b0;
        if (!load) begin
            unique case (phase_q)
                PH_IDLE:     ;
                PH_ACCUM:    take   = in_valid;
                PH_CLAMP:    arg_en = 1'b1;
                PH_ACTIVATE: res_en = 1'b1;
            endcase
        end
    end

    // Accepted-sample counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= '0;
        end else if (take) begin
            cnt_q <= at_last ? '0 : cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/neuron_mac.sv
module neuron_mac #(
    parameter int DATA_W = 8,
    parameter int BIAS_W = 16,
    parameter int ACC_W  = 21
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    seed,
    input  logic                    take,
    input  logic [BIAS_W-1:0]       bias,
    input  logic [DATA_W-1:0]       in_x,
    input  logic [DATA_W-1:0]       in_w,
    output logic signed [ACC_W-1:0] acc
);

    localparam int PROD_W = 2 * DATA_W;

    logic signed [PROD_W-1:0] prod;
    logic signed [ACC_W-1:0]  prod_ext;
    logic signed [ACC_W-1:0]  bias_ext;

    assign prod     = $signed(in_x) * $signed(in_w);
    assign prod_ext = ACC_W'(prod);
    assign bias_ext = ACC_W'($signed(bias));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc <= '0;
        end else if (seed) begin
            acc <= bias_ext;
        end else if (take) begin
            acc <= acc + prod_ext;
        end
    end

endmodule

// File: rtl/neuron_clamp.sv
module neuron_clamp
    import neuron_pkg::*;
#(
    parameter int ACC_W = 21
) (
    input  logic signed [ACC_W-1:0] acc,
    output logic [ARG_W-1:0]        arg
);

    localparam logic signed [ACC_W:0] MID = (ACC_W+1)'(ARG_MID);
    localparam logic signed [ACC_W:0] TOP = (ACC_W+1)'(ARG_MAX);

    logic signed [ACC_W:0] shifted;

    always_comb begin
        shifted = (ACC_W+1)'(acc) + MID;
        if (shifted < 0) begin
            arg = '0;
        end else if (shifted > TOP) begin
            arg = ARG_W'(ARG_MAX);
        end else begin
            arg = ARG_W'(shifted);
        end
    end

endmodule

// File: rtl/neuron_sigmoid.sv
module neuron_sigmoid
    import neuron_pkg::*;
(
    input  logic [ARG_W-1:0] arg,
    output logic [Y_W-1:0]   y
);

    logic       upper;
    logic [7:0] mag;
    logic [1:0] seg;
    int         t;
    int         poly;
    int         g;
    logic [7:0] ypos;

    always_comb begin
        upper = arg[ARG_W-1];
        mag   = upper ? arg[7:0] : 8'(ARG_W'(ARG_MID) - arg);
        seg   = mag[7:6];
        t     = int'(mag[5:0]);
        poly  = coef_base(seg) * 4096 + coef_lin(seg) * t * 64
              + coef_quad(seg) * t * t;
        g     = poly >>> 16;
        if (g > Y_MAX - Y_MID) g = Y_MAX - Y_MID;
        if (g < 0) g = 0;
        ypos  = 8'(Y_MID + g);
        if (arg == ARG_W'(0)) begin
            y = '0;
        end else if (arg == ARG_W'(ARG_MAX)) begin
            y = Y_W'(Y_MAX);
        end else if (upper) begin
            y = ypos;
        end else begin
            y = Y_W'(Y_MAX) - ypos;
        end
    end

endmodule

// File: rtl/serial_neuron.sv
module serial_neuron
    import neuron_pkg::*;
#(
    parameter int FAN_IN = 8,
    parameter int DATA_W = 8,
    parameter int BIAS_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [BIAS_W-1:0] bias,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_x,
    input  logic [DATA_W-1:0] in_w,
    output logic [Y_W-1:0]    out_y,
    output logic              out_valid
);

    localparam int PROD_W = 2 * DATA_W;
    localparam int SUM_W  = PROD_W + $clog2(FAN_IN + 1);
    localparam int ACC_W  = ((SUM_W > BIAS_W) ? SUM_W : BIAS_W) + 1;

    phase_t                  phase;
    logic                    seed;
    logic                    take;
    logic                    arg_en;
    logic                    res_en;
    logic signed [ACC_W-1:0] acc;
    logic [ARG_W-1:0]        arg_d;
    logic [ARG_W-1:0]        arg_q;
    logic [Y_W-1:0]          y_d;

    neuron_ctrl #(.FAN_IN(FAN_IN)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .in_valid (in_valid),
        .phase    (phase),
        .seed     (seed),
        .take     (take),
        .arg_en   (arg_en),
        .res_en   (res_en)
    );

    neuron_mac #(.DATA_W(DATA_W), .BIAS_W(BIAS_W), .ACC_W(ACC_W)) u_mac (
        .clk   (clk),
        .rst_n (rst_n),
        .seed  (seed),
        .take  (take),
        .bias  (bias),
        .in_x  (in_x),
        .in_w  (in_w),
        .acc   (acc)
    );

    neuron_clamp #(.ACC_W(ACC_W)) u_clamp (
        .acc (acc),
        .arg (arg_d)
    );

    neuron_sigmoid u_sig (
        .arg (arg_q),
        .y   (y_d)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            arg_q <= '0;
        end else if (arg_en) begin
            arg_q <= arg_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_y     <= '0;
            out_valid <= 1'b0;
        end else begin
            out_valid <= res_en;
            if (res_en) begin
                out_y <= y_d;
            end
        end
    end

endmodule

// File: rtl/neuron_checker.sv
module neuron_checker
    import neuron_pkg::*;
#(
    parameter int ACC_W  = 21,
    parameter int BIAS_W = 16
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    load,
    input logic                    in_valid,
    input logic [BIAS_W-1:0]       bias,
    input phase_t                  phase,
    input logic signed [ACC_W-1:0] acc,
    input logic [ARG_W-1:0]        arg_q,
    input logic [Y_W-1:0]          out_y,
    input logic                    out_valid
);

    localparam logic signed [ACC_W-1:0] LO_LIM = -ACC_W'(256);
    localparam logic signed [ACC_W-1:0] HI_LIM = ACC_W'(255);

    a_r3_bias_seed: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (acc == ACC_W'($signed($past(bias)))));

    a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid);

    a_r5_after_activate: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(phase == PH_ACTIVATE && !load));

    a_r9_load_cancels: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> !out_valid);

    a_r10_idle_ignores: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_IDLE && in_valid && !load) |=> $stable(acc));

    a_r6_clamp_low: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_CLAMP && !load && acc <= LO_LIM) |=> (arg_q == '0));

    a_r6_clamp_high: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_CLAMP && !load && acc >= HI_LIM) |=> (arg_q == ARG_W'(ARG_MAX)));

    a_r7_end_points: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ((arg_q != '0 || out_y == '0) &&
                       (arg_q != ARG_W'(ARG_MAX) || out_y == Y_W'(Y_MAX))));

endmodule

bind serial_neuron neuron_checker #(.ACC_W(ACC_W), .BIAS_W(BIAS_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (load),
    .in_valid  (in_valid),
    .bias      (bias),
    .phase     (phase),
    .acc       (acc),
    .arg_q     (arg_q),
    .out_y     (out_y),
    .out_valid (out_valid)
);

// File: tb/tb_serial_neuron.sv
`timescale 1ns/1ps
module tb_serial_neuron;

    localparam int N  = 8;
    localparam int DW = 8;
    localparam int BW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          load = 1'b0;
    logic [BW-1:0] bias = '0;
    logic          in_valid = 1'b0;
    logic [DW-1:0] in_x = '0;
    logic [DW-1:0] in_w = '0;
    logic [7:0]    out_y;
    logic          out_valid;

    int n_run  = 0;
    int n_fail = 0;
    int sweep_y [512];

    always #5 clk = ~clk;

    serial_neuron #(.FAN_IN(N), .DATA_W(DW), .BIAS_W(BW)) dut (
        .clk (clk), .rst_n (rst_n), .load (load), .bias (bias),
        .in_valid (in_valid), .in_x (in_x), .in_w (in_w),
        .out_y (out_y), .out_valid (out_valid)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int xval(input int p, input int i);
        if (p < 0) return 0;
        if (p == 100 || p == 101) return -128;
        return ((i * 29 + p * 53) % 41) - 20;
    endfunction

    function automatic int wval(input int p, input int i);
        if (p < 0) return 0;
        if (p == 100) return -128;
        if (p == 101) return 127;
        return ((i * 17 + p * 11) % 23) - 11;
    endfunction

    function automatic int to_arg(input int s);
        int a;
        a = s + 256;
        if (a < 0) a = 0;
        if (a > 511) a = 511;
        return a;
    endfunction

    function automatic real ideal(input int a);
        return 255.0 / (1.0 + $exp(-(real'(a) - 256.0) / 32.0));
    endfunction

    task automatic start_pass(input int b);
        @(negedge clk);
        load = 1'b1; bias = BW'(b); in_valid = 1'b0;
    endtask

    task automatic feed(input int p, input int count, input bit gaps, inout int acc);
        for (int i = 0; i < count; i++) begin
            if (gaps && (i % 2 == 1)) begin
                @(negedge clk);
                load = 1'b0; in_valid = 1'b0;
            end
            @(negedge clk);
            load = 1'b0; in_valid = 1'b1;
            in_x = DW'(xval(p, i)); in_w = DW'(wval(p, i));
            acc += xval(p, i) * wval(p, i);
        end
    endtask

    // Edge 1 takes the last sample; result is due after edge 3.
    task automatic finish_pass(input string req, input bit have, input int exp, output int got);
        @(negedge clk);
        check(out_valid == 1'b0, "R5 early strobe edge1", int'(out_valid), 0);
        load = 1'b0; in_valid = 1'b0;
        @(negedge clk);
        check(out_valid == 1'b0, "R5 early strobe edge2", int'(out_valid), 0);
        @(negedge clk);
        check(out_valid == 1'b1, "R5 strobe after edge3", int'(out_valid), 1);
        got = int'(out_y);
        if (have) check(int'(out_y) == exp, req, int'(out_y), exp);
        @(negedge clk);
        check(out_valid == 1'b0, "R5 strobe one cycle", int'(out_valid), 0);
        check(int'(out_y) == got, "R5 output held", int'(out_y), got);
    endtask

    task automatic quiet_window(input int cycles, input string req, input int hold_y);
        for (int c = 0; c < cycles; c++) begin
            @(negedge clk);
            check(out_valid == 1'b0, req, int'(out_valid), 0);
            check(int'(out_y) == hold_y, req, int'(out_y), hold_y);
            load = 1'b0; in_valid = 1'b0;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        int acc;
        int got;
        int a;
        real err;

        // R1: reset values
        repeat (3) @(negedge clk);
        check(out_valid == 1'b0, "R1 valid in reset", int'(out_valid), 0);
        check(out_y == 8'd0, "R1 output in reset", int'(out_y), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(out_valid == 1'b0 && out_y == 8'd0, "R1 after release", int'(out_y), 0);

        // R2: samples before the first load are ignored
        for (int i = 0; i < N + 3; i++) begin
            @(negedge clk);
            check(out_valid == 1'b0, "R2 no strobe before load", int'(out_valid), 0);
            load = 1'b0; in_valid = 1'b1; in_x = 8'sd90; in_w = 8'sd90;
        end
        quiet_window(4, "R2 no strobe before load", 0);

        // R7/R8: sweep every argument through the bias, zero inputs
        for (int s = 0; s < 512; s++) begin
            start_pass(s - 256);
            acc = s - 256;
            feed(-1, N, 1'b0, acc);
            finish_pass("", 1'b0, 0, got);
            sweep_y[s] = got;
            err = real'(got) - ideal(s);
            if (err < 0.0) err = -err;
            check(err <= 4.0, "R7 within 4 LSB of ideal", got, int'(ideal(s)));
            if (s > 0) check(got >= sweep_y[s-1], "R8 monotonic", got, sweep_y[s-1]);
        end
        check(sweep_y[0] == 0, "R7 argument 0", sweep_y[0], 0);
        check(sweep_y[511] == 255, "R7 argument 511", sweep_y[511], 255);
        check(sweep_y[256] == 128, "R7 argument 256", sweep_y[256], 128);

        // R2: first real pass unaffected by the ignored samples
        start_pass(-37);
        acc = -37;
        feed(5, N, 1'b0, acc);
        finish_pass("R2 pass after ignored samples", 1'b1, sweep_y[to_arg(acc)], got);

        // R4: mixed-sign patterns, with and without gaps
        for (int p = 0; p < 24; p++) begin
            start_pass(p * 41 - 480);
            acc = p * 41 - 480;
            feed(p, N, p[0], acc);
            finish_pass("R4 weighted sum", 1'b1, sweep_y[to_arg(acc)], got);
        end

        // R6: saturation at both ends, including large products
        start_pass(-32768); acc = -32768; feed(100, N, 1'b0, acc);
        finish_pass("R6 saturate high products", 1'b1, 255, got);
        start_pass(32767); acc = 32767; feed(101, N, 1'b0, acc);
        finish_pass("R6 saturate low products", 1'b1, 0, got);
        start_pass(300); acc = 300; feed(-1, N, 1'b0, acc);
        finish_pass("R6 saturate high bias", 1'b1, 255, got);
        start_pass(-700); acc = -700; feed(-1, N, 1'b0, acc);
        finish_pass("R6 saturate low bias", 1'b1, 0, got);

        // R3: load wins over a sample in the same cycle
        start_pass(999);
        @(negedge clk);
        load = 1'b1; bias = BW'(20); in_valid = 1'b1; in_x = 8'sd100; in_w = 8'sd100;
        acc = 20;
        feed(7, N, 1'b0, acc);
        finish_pass("R3 load beats sample", 1'b1, sweep_y[to_arg(acc)], got);

        // R9: reload in mid-pass discards the partial sum
        start_pass(200);
        acc = 200;
        feed(9, 3, 1'b0, acc);
        start_pass(-60);
        acc = -60;
        feed(11, N, 1'b0, acc);
        finish_pass("R9 R3 mid-pass reload", 1'b1, sweep_y[to_arg(acc)], got);

        // R9: load in the clamp stage cancels the result
        a = got;
        start_pass(100);
        acc = 100;
        feed(3, N, 1'b0, acc);
        @(negedge clk);
        load = 1'b1; bias = BW'(-10); in_valid = 1'b0;
        quiet_window(6, "R9 cancel at clamp stage", a);
        acc = -10;
        feed(13, N, 1'b0, acc);
        finish_pass("R9 pass after cancel", 1'b1, sweep_y[to_arg(acc)], got);

        // R9: load in the activate stage cancels the result
        a = got;
        start_pass(-150);
        acc = -150;
        feed(15, N, 1'b0, acc);
        @(negedge clk);
        load = 1'b0; in_valid = 1'b0;
        @(negedge clk);
        load = 1'b1; bias = BW'(40);
        quiet_window(6, "R9 cancel at activate stage", a);
        acc = 40;
        feed(17, N, 1'b1, acc);
        finish_pass("R9 pass after late cancel", 1'b1, sweep_y[to_arg(acc)], got);

        // R10: samples after a result are ignored until the next load
        a = got;
        for (int i = 0; i < N + 2; i++) begin
            @(negedge clk);
            check(out_valid == 1'b0 && int'(out_y) == a, "R10 idle after result", int'(out_y), a);
            load = 1'b0; in_valid = 1'b1; in_x = 8'sd77; in_w = -8'sd77;
        end
        quiet_window(4, "R10 idle after result", a);
        start_pass(-5);
        acc = -5;
        feed(19, N, 1'b0, acc);
        finish_pass("R10 pass after idle samples", 1'b1, sweep_y[to_arg(acc)], got);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule